// File: doc/BRIEF.md
# Processor Reset Initialization Sequencer

This block brings a simple CPU core out of reset. While the synchronous reset input is high it holds the core quiet: it keeps the pipeline flushed, the bus idle, and the cache invalidated and disabled, with paging off. Once reset drops, it counts a startup delay before fetching begins. The length of that delay depends on the clock-scaling mode. When a self-test is requested, a fixed extra interval is added to the delay.

At the end of the count the block sends out a one-cycle fetch-start pulse that carries the first fetch address. In the same cycle it loads the architectural reset values: code segment, instruction pointer, flags, control register 0, debug control, and the accumulator and data registers. The accumulator reports the self-test outcome. The data register reports a fixed family code and a device identifier. A pass/fail input stands in for the real self-test logic.

The configuration inputs are sampled while reset is held, so they may change freely once the delay has begun.

Top module: `reset_init_seq`

## Requirements
- R1: While `rst` is sampled high, every following cycle shows `pipe_flush`, `bus_idle`, `cache_inval`, `cache_dis` and `paging_off` high, and `fetch_start` and `init_valid` low.
- R2: Call the first rising edge with `rst` low edge 1. `fetch_start` is high only after edge N, where N is `DLY_2X` (default 150) when `mode_3x`=0 and `DLY_3X` (default 250) when `mode_3x`=1.
- R3: When `selftest_req` is 1, N grows by `SELFTEST_DLY` (default 220).
- R4: If `rst` is asserted again during the delay, the count starts over and no `fetch_start` appears before a full new delay has elapsed.
- R5: `fetch_start` lasts exactly one cycle, and `fetch_addr` equals 32'hFFFF_FFF0 in that cycle.
- R6: From the pulse on, `init_valid` is 1, `cs_init`=16'hF000, `eip_init`=32'h0000_FFF0, `eflags_init`=32'h0000_0002, `cr0_init`=32'h6000_0010 and `dr7_init`=32'h0000_0400.
- R7: `eax_init` is 0 unless self-test was requested and `selftest_pass` was 0 at the pulse edge. In that case it is 32'h0000_0001.
- R8: `edx_init` = {16'h0000, 8'h05, id}. The id is 8'h31 with bit 2 set when `mode_3x`=1 and bit 1 set when `id_alt`=1, giving 31h, 33h, 35h or 37h.
- R9: After the pulse, `pipe_flush`, `bus_idle` and `cache_inval` are low, and every initial-value output stays unchanged until the next reset. `cache_dis` and `paging_off` remain high, following `cr0_init` bits 30 and 31.
- R10: Changes to `mode_3x`, `selftest_req` and `id_alt` while `rst` is low do not alter the delay or `edx_init`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_3x | input | 1 | Clock-scaling select: 0 = 2x, 1 = 3x |
| selftest_req | input | 1 | Request self-test interval |
| id_alt | input | 1 | Selects the alternate device id |
| selftest_pass | input | 1 | Self-test outcome stand-in |
| pipe_flush | output | 1 | Hold pipelines flushed |
| bus_idle | output | 1 | Suppress bus cycles |
| cache_inval | output | 1 | Invalidate cache (reset only) |
| cache_dis | output | 1 | Cache disabled |
| paging_off | output | 1 | Paging disabled |
| fetch_start | output | 1 | One-cycle start-of-fetch pulse |
| fetch_addr | output | 32 | First fetch address |
| init_valid | output | 1 | Initial values loaded |
| eax_init | output | 32 | Accumulator reset value |
| edx_init | output | 32 | Data register reset value |
| eflags_init | output | 32 | Flags reset value |
| eip_init | output | 32 | Instruction pointer reset value |
| cs_init | output | 16 | Code segment reset value |
| cr0_init | output | 32 | Control register 0 reset value |
| dr7_init | output | 32 | Debug control reset value |

## Verification
The assertions assume that the bench holds `rst` high from time zero for at least one edge, so every register has a known value before any property is enabled. They also assume that `selftest_pass` does not change in the cycle of the pulse edge. The bench drives every input on the falling edge, keeps reset high for several cycles before each release, and holds `selftest_pass` constant for the whole of each run. Within those limits it draws random modes and configuration changes after release, and it cuts delays short at random points with a new reset.

// File: rtl/reset_init_seq.sv
module reset_init_seq #(
  parameter int DLY_2X       = 150,
  parameter int DLY_3X       = 250,
  parameter int SELFTEST_DLY = 220
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mode_3x,
  input  logic        selftest_req,
  input  logic        id_alt,
  input  logic        selftest_pass,
  output logic        pipe_flush,
  output logic        bus_idle,
  output logic        cache_inval,
  output logic        cache_dis,
  output logic        paging_off,
  output logic        fetch_start,
  output logic [31:0] fetch_addr,
  output logic        init_valid,
  output logic [31:0] eax_init,
  output logic [31:0] edx_init,
  output logic [31:0] eflags_init,
  output logic [31:0] eip_init,
  output logic [15:0] cs_init,
  output logic [31:0] cr0_init,
  output logic [31:0] dr7_init
);
  localparam int MAXDLY = ((DLY_3X > DLY_2X) ? DLY_3X : DLY_2X) + SELFTEST_DLY;
  localparam int CW     = $clog2(MAXDLY + 1);

  localparam logic [15:0] CS_RST   = 16'hF000;
  localparam logic [31:0] EIP_RST  = 32'h0000_FFF0;
  localparam logic [31:0] FLG_RST  = 32'h0000_0002;
  localparam logic [31:0] CR0_RST  = 32'h6000_0010;
  localparam logic [31:0] DR7_RST  = 32'h0000_0400;
  localparam logic [7:0]  FAMILY   = 8'h05;

  typedef enum logic [1:0] {PH_HOLD, PH_WAIT, PH_RUN} phase_t;

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [CW-1:0] tgt;
  logic          st_q, m3_q, alt_q;
  logic          fire;

  assign fire = (phase != PH_RUN) && (cnt == tgt - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_HOLD;
      cnt   <= '0;
      tgt   <= CW'(mode_3x ? DLY_3X : DLY_2X) + (selftest_req ? CW'(SELFTEST_DLY) : CW'(0));
      st_q  <= selftest_req;
      m3_q  <= mode_3x;
      alt_q <= id_alt;
    end else if (phase != PH_RUN) begin
      if (fire) phase <= PH_RUN;
      else begin
        phase <= PH_WAIT;
        cnt   <= cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_start <= 1'b0;
      init_valid  <= 1'b0;
      eax_init    <= '0;
      edx_init    <= '0;
      eflags_init <= '0;
      eip_init    <= '0;
      cs_init     <= '0;
      cr0_init    <= '0;
      dr7_init    <= '0;
      fetch_addr  <= '0;
    end else begin
      fetch_start <= fire;
      if (fire) begin
        init_valid  <= 1'b1;
        eax_init    <= (st_q && !selftest_pass) ? 32'h0000_0001 : 32'h0;
        edx_init    <= {16'h0000, FAMILY, 5'b00110, m3_q, alt_q, 1'b1};
        eflags_init <= FLG_RST;
        eip_init    <= EIP_RST;
        cs_init     <= CS_RST;
        cr0_init    <= CR0_RST;
        dr7_init    <= DR7_RST;
        fetch_addr  <= {16'hFFFF, 16'h0000} + {12'h0, CS_RST, 4'h0} - 32'h000F_0000 + EIP_RST;
      end
    end
  end

  assign pipe_flush  = (phase != PH_RUN);
  assign bus_idle    = (phase != PH_RUN);
  assign cache_inval = (phase == PH_HOLD);
  assign cache_dis   = (phase != PH_RUN) | cr0_init[30];
  assign paging_off  = (phase != PH_RUN) | ~cr0_init[31];

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pipe_flush && bus_idle && !fetch_start && !init_valid));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    fetch_start |=> !fetch_start);

  a_r5_fetch_address: assert property (@(posedge clk) disable iff (rst)
    fetch_start |-> (fetch_addr == 32'hFFFF_FFF0 && init_valid));

  a_r9_values_hold: assert property (@(posedge clk) disable iff (rst)
    init_valid |=> (init_valid && $stable(eax_init) && $stable(edx_init) &&
                    $stable(cr0_init) && $stable(eip_init) && !pipe_flush));

  a_r6_fetch_starts_load: assert property (@(posedge clk) disable iff (rst)
    $rose(init_valid) |-> fetch_start);

  a_r9_inval_only_hold: assert property (@(posedge clk) disable iff (rst)
    fetch_start |-> (!cache_inval && !bus_idle));
endmodule

// File: tb/reset_init_seq_test.sv
module reset_init_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int D2 = 150, D3 = 250, DST = 220;

  logic clk = 1'b0;
  logic rst = 1'b1, mode_3x = 1'b0, selftest_req = 1'b0, id_alt = 1'b0, selftest_pass = 1'b1;
  logic pipe_flush, bus_idle, cache_inval, cache_dis, paging_off, fetch_start, init_valid;
  logic [31:0] fetch_addr, eax_init, edx_init, eflags_init, eip_init, cr0_init, dr7_init;
  logic [15:0] cs_init;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_init_seq #(.DLY_2X(D2), .DLY_3X(D3), .SELFTEST_DLY(DST)) uut (
    .clk(clk), .rst(rst), .mode_3x(mode_3x), .selftest_req(selftest_req), .id_alt(id_alt),
    .selftest_pass(selftest_pass), .pipe_flush(pipe_flush), .bus_idle(bus_idle),
    .cache_inval(cache_inval), .cache_dis(cache_dis), .paging_off(paging_off),
    .fetch_start(fetch_start), .fetch_addr(fetch_addr), .init_valid(init_valid),
    .eax_init(eax_init), .edx_init(edx_init), .eflags_init(eflags_init), .eip_init(eip_init),
    .cs_init(cs_init), .cr0_init(cr0_init), .dr7_init(dr7_init));

  function automatic int exp_delay(bit m3, bit st);
    return (m3 ? D3 : D2) + (st ? DST : 0);
  endfunction
  function automatic logic [31:0] exp_edx(bit m3, bit alt);
    return {16'h0, 8'h05, 8'h31 | (m3 ? 8'h04 : 8'h00) | (alt ? 8'h02 : 8'h00)};
  endfunction
  function automatic logic [31:0] exp_eax(bit st, bit pass);
    return (st && !pass) ? 32'h1 : 32'h0;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold_reset(bit m3, bit st, bit alt, bit pass);
    @(negedge clk);
    rst = 1'b1; mode_3x = m3; selftest_req = st; id_alt = alt; selftest_pass = pass;
    repeat (3) @(negedge clk);
    check(pipe_flush && bus_idle && cache_inval && cache_dis && paging_off && !fetch_start && !init_valid,
          "R1", {25'h0, pipe_flush, bus_idle, cache_inval, cache_dis, paging_off, fetch_start, init_valid},
          32'h7C);
  endtask

  task automatic run_case(bit m3, bit st, bit alt, bit pass, bit scramble);
    int n = exp_delay(m3, st);
    int early = 0;
    hold_reset(m3, st, alt, pass);
    rst = 1'b0;
    for (int i = 1; i <= n + 1; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (scramble) begin
        mode_3x = 1'($urandom); selftest_req = 1'($urandom); id_alt = 1'($urandom);
      end
      if (i < n && (fetch_start || !pipe_flush)) early++;
      if (i == n) begin
        check(early == 0, st ? "R3" : "R2", early, 0);
        check(fetch_start == 1'b1, st ? "R3" : "R2", fetch_start, 1);
        check(fetch_addr == 32'hFFFF_FFF0, "R5", fetch_addr, 32'hFFFF_FFF0);
        check(init_valid && cs_init == 16'hF000 && eip_init == 32'h0000_FFF0 &&
              eflags_init == 32'h2 && cr0_init == 32'h6000_0010 && dr7_init == 32'h400,
              "R6", {cs_init, eip_init[15:0]}, 32'hF000_FFF0);
        check(eax_init == exp_eax(st, pass), "R7", eax_init, exp_eax(st, pass));
        check(edx_init == exp_edx(m3, alt), scramble ? "R10" : "R8", edx_init, exp_edx(m3, alt));
      end
    end
    check(fetch_start == 1'b0, "R5", fetch_start, 0);
    repeat (5) @(negedge clk);
    check(!pipe_flush && !bus_idle && !cache_inval && cache_dis && paging_off && init_valid,
          "R9", {26'h0, pipe_flush, bus_idle, cache_inval, cache_dis, paging_off, init_valid}, 32'h7);
    check(eax_init == exp_eax(st, pass) && edx_init == exp_edx(m3, alt), "R9", edx_init, exp_edx(m3, alt));
  endtask

  task automatic abort_case(bit m3, bit st, int k);
    hold_reset(m3, st, 1'b0, 1'b1);
    rst = 1'b0;
    repeat (k) @(negedge clk);
    check(!fetch_start && !init_valid, "R4", fetch_start, 0);
    run_case(m3, st, 1'b1, 1'b1, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    run_case(0, 0, 0, 1, 0);
    run_case(1, 0, 1, 1, 0);
    run_case(0, 1, 0, 1, 0);
    run_case(1, 1, 1, 0, 0);
    run_case(0, 1, 1, 0, 1);
    abort_case(1, 0, 249);
    abort_case(0, 1, 1);
    for (int t = 0; t < 10; t++) begin
      bit m3 = 1'($urandom), st = 1'($urandom), alt = 1'($urandom), ps = 1'($urandom);
      bit sc = 1'($urandom);
      if ($urandom_range(0, 3) == 0) abort_case(m3, st, $urandom_range(1, exp_delay(m3, st) - 1));
      else run_case(m3, st, alt, ps, sc);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule